// File: doc/BRIEF.md
# Trail Trace Identifier Transmitter

This block holds a trail trace identifier of sixteen bytes for the transmit direction and hands it to the overhead formatter one byte at a time. Each time the formatter pulses its byte request, the block presents the next identifier byte and steps a 4-bit index. After byte 15 the index returns to byte 0, so the identifier repeats for as long as requests arrive. The transmit path has no link to any receive logic.

Software writes identifier bytes through a simple write port into a staging copy. The staged copy moves into the copy being sent only when byte 0 of a new multiframe is requested, so a sequence already on the line never mixes old and new content. Two controls shape each outgoing byte. The first forces the multiframe alignment marker into the top bit: 1 for byte 0 and 0 for the other fifteen bytes. The second inverts the whole byte, and it acts after the marker. A serial output presents the same formatted byte one bit per bit strobe, most significant bit first by default.

Top module: `trail_id_tx`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `out_byte` = 0, `out_idx` = 0 and `ser_out` = 0, and the first byte request emits identifier byte 0.
- R2: Each byte request steps the internal index by one, and after index 15 it returns to 0. `out_idx`, updated one cycle after the request, reports the index of the byte now on `out_byte`.
- R3: With `align_en` = 0 and `invert_en` = 0, `out_byte` equals the stored identifier byte at `out_idx`, unchanged.
- R4: With `align_en` = 1, bit 7 of `out_byte` is 1 for byte 0 and 0 for bytes 1 to 15. Bits 6:0 carry the stored byte.
- R5: With `invert_en` = 1, `out_byte` is the bitwise complement of the byte after marker insertion. With both controls set, bit 7 is therefore 0 for byte 0 and 1 for every other byte.
- R6: A write (`wr_en` = 1 stores `wr_data` at byte `wr_addr`) reaches the output only from the next byte-0 request after the write cycle. A write in the same cycle as a byte-0 request applies to the multiframe after that one.
- R7: After a byte request, `ser_out` shows bit 7 of the new `out_byte`. Each later `bit_req` moves `ser_out` to the next lower bit.
- R8: When `byte_req` and `bit_req` are high in the same cycle, the load wins: `ser_out` shows bit 7 of the new byte.
- R9: In cycles with no byte request, `out_byte` and `out_idx` hold their values. In cycles with neither request, `ser_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the staging copy |
| wr_addr | input | 4 | Identifier byte index to write |
| wr_data | input | 8 | Identifier byte value |
| align_en | input | 1 | Force the multiframe marker into bit 7 |
| invert_en | input | 1 | Invert each output byte |
| byte_req | input | 1 | Formatter request for the next byte |
| bit_req | input | 1 | Serial shift strobe |
| out_byte | output | 8 | Formatted identifier byte |
| out_idx | output | 4 | Index of the byte on out_byte |
| ser_out | output | 1 | Serial bit of the current byte |

## Verification
Two events can land in one cycle: a register write and the byte-0 request that copies the staged identifier into the sending copy. The bench writes byte 0 in exactly the cycle of a byte-0 request. It expects the old value for that multiframe and the new value one multiframe later. It also raises the byte and bit strobes together and expects the serial output to show the top bit of the newly loaded byte, not a shifted bit.

// File: rtl/trail_id_pkg.sv
package trail_id_pkg;
   typedef enum logic {ORDER_MSB = 1'b0, ORDER_LSB = 1'b1} bit_order_e;

   typedef struct packed {
      logic align;
      logic invert;
   } tid_ctl_t;
endpackage

// File: rtl/trail_id_seq.sv
module trail_id_seq #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             byte_req,
   output logic [IDX_W-1:0] idx,
   output logic             frame_start
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (rst)
         idx <= '0;
      else if (byte_req)
         idx <= (idx == LAST) ? '0 : idx + 1'b1;
   end

   assign frame_start = byte_req && (idx == '0);

   // R2
   idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (byte_req && idx == LAST) |=> (idx == '0));

   // R2
   idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !byte_req |=> $stable(idx));
endmodule

// File: rtl/trail_id_bank.sv
module trail_id_bank #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [W-1:0]     wr_data,
   input  logic             frame_start,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [W-1:0]     rd_data
);
   logic [W-1:0] staged [DEPTH];
   logic [W-1:0] live   [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) staged[i] <= '0;
      end else if (wr_en) begin
         staged[wr_addr] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) live[i] <= '0;
      end else if (frame_start) begin
         for (int i = 0; i < DEPTH; i++) live[i] <= staged[i];
      end
   end

   // the byte-0 request reads the staged copy directly, so byte 0 of a new
   // multiframe already carries the committed content
   assign rd_data = frame_start ? staged[rd_idx] : live[rd_idx];

   for (genvar g = 0; g < DEPTH; g++) begin : g_live_chk
      // R6
      live_hold_chk: assert property (@(posedge clk) disable iff (rst)
         !frame_start |=> $stable(live[g]));
   end
endmodule

// File: rtl/trail_id_fmt.sv
module trail_id_fmt
   import trail_id_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] raw,
   input  logic         first,
   input  tid_ctl_t     ctl,
   output logic [W-1:0] shaped
);
   logic [W-1:0] marked;

   always_comb begin
      marked = raw;
      if (ctl.align) marked[W-1] = first;
      shaped = ctl.invert ? ~marked : marked;
   end
endmodule

// File: rtl/trail_id_ser.sv
module trail_id_ser
   import trail_id_pkg::*;
#(
   parameter int         W     = 8,
   parameter bit_order_e ORDER = ORDER_MSB
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         shift,
   output logic         ser_out
);
   logic [W-1:0] sh;

   if (ORDER == ORDER_MSB) begin : g_msb
      always_ff @(posedge clk) begin
         if (rst)        sh <= '0;
         else if (load)  sh <= load_data;
         else if (shift) sh <= {sh[W-2:0], 1'b0};
      end
      assign ser_out = sh[W-1];

      // R8
      ser_load_chk: assert property (@(posedge clk) disable iff (rst)
         load |=> (ser_out == $past(load_data[W-1])));
   end else begin : g_lsb
      always_ff @(posedge clk) begin
         if (rst)        sh <= '0;
         else if (load)  sh <= load_data;
         else if (shift) sh <= {1'b0, sh[W-1:1]};
      end
      assign ser_out = sh[0];

      // R8
      ser_load_chk: assert property (@(posedge clk) disable iff (rst)
         load |=> (ser_out == $past(load_data[0])));
   end

   // R9
   ser_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!load && !shift) |=> $stable(ser_out));
endmodule

// File: rtl/trail_id_tx.sv
module trail_id_tx
   import trail_id_pkg::*;
#(
   parameter int         DEPTH  = 16,
   parameter int         BYTE_W = 8,
   parameter bit_order_e ORDER  = ORDER_MSB,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              align_en,
   input  logic              invert_en,
   input  logic              byte_req,
   input  logic              bit_req,
   output logic [BYTE_W-1:0] out_byte,
   output logic [IDX_W-1:0]  out_idx,
   output logic              ser_out
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("trail_id_tx: DEPTH must be a power of two of at least 2");
   end
   if (BYTE_W < 2) begin : g_bad_width
      $error("trail_id_tx: BYTE_W must be at least 2");
   end

   logic [IDX_W-1:0]  idx;
   logic              frame_start;
   logic [BYTE_W-1:0] raw_byte;
   logic [BYTE_W-1:0] shaped_byte;
   tid_ctl_t          ctl;

   assign ctl = '{align: align_en, invert: invert_en};

   trail_id_seq #(.DEPTH(DEPTH)) u_seq (
      .clk         (clk),
      .rst         (rst),
      .byte_req    (byte_req),
      .idx         (idx),
      .frame_start (frame_start)
   );

   trail_id_bank #(.DEPTH(DEPTH), .W(BYTE_W)) u_bank (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .frame_start (frame_start),
      .rd_idx      (idx),
      .rd_data     (raw_byte)
   );

   trail_id_fmt #(.W(BYTE_W)) u_fmt (
      .raw    (raw_byte),
      .first  (idx == '0),
      .ctl    (ctl),
      .shaped (shaped_byte)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_byte <= '0;
         out_idx  <= '0;
      end else if (byte_req) begin
         out_byte <= shaped_byte;
         out_idx  <= idx;
      end
   end

   trail_id_ser #(.W(BYTE_W), .ORDER(ORDER)) u_ser (
      .clk       (clk),
      .rst       (rst),
      .load      (byte_req),
      .load_data (shaped_byte),
      .shift     (bit_req),
      .ser_out   (ser_out)
   );

   // R4
   marker_chk: assert property (@(posedge clk) disable iff (rst)
      (byte_req && align_en && !invert_en) |=> (out_byte[BYTE_W-1] == (out_idx == '0)));

   // R5
   inv_marker_chk: assert property (@(posedge clk) disable iff (rst)
      (byte_req && align_en && invert_en) |=> (out_byte[BYTE_W-1] == (out_idx != '0)));

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !byte_req |=> ($stable(out_byte) && $stable(out_idx)));
endmodule

// File: tb/trail_id_tx_bench.sv
module trail_id_tx_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       align_en = 1'b0;
   logic       invert_en = 1'b0;
   logic       byte_req = 1'b0;
   logic       bit_req = 1'b0;
   logic [7:0] out_byte;
   logic [3:0] out_idx;
   logic       ser_out;

   always #5 clk = ~clk;

   trail_id_tx u_trail_id_tx (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .align_en(align_en), .invert_en(invert_en), .byte_req(byte_req),
      .bit_req(bit_req), .out_byte(out_byte), .out_idx(out_idx), .ser_out(ser_out)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] m_stage [16];
   logic [7:0] m_live  [16];
   logic [3:0] m_idx = '0;
   logic [7:0] m_out = '0;
   logic [3:0] m_oidx = '0;
   logic [7:0] m_sh = '0;

   function automatic logic [7:0] fm(input logic [7:0] b, input logic first,
                                     input logic al, input logic iv);
      logic [7:0] r;
      r = b;
      if (al) r[7] = first;
      return iv ? ~r : r;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic rq, input logic bq, input logic wr,
                       input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      byte_req = rq; bit_req = bq; wr_en = wr; wr_addr = a; wr_data = d;
      @(negedge clk);
      byte_req = 1'b0; bit_req = 1'b0; wr_en = 1'b0;
      if (rq) begin
         if (m_idx == 0) for (int i = 0; i < 16; i++) m_live[i] = m_stage[i];
         m_out  = fm(m_live[m_idx], m_idx == 0, align_en, invert_en);
         m_oidx = m_idx;
         m_idx  = m_idx + 1'b1;
         m_sh   = m_out;
      end else if (bq) begin
         m_sh = {m_sh[6:0], 1'b0};
      end
      if (wr) m_stage[a] = d;
   endtask

   task automatic send(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         step(1'b1, 1'b0, 1'b0, 4'd0, 8'd0);
         chk(out_byte == m_out, tag, out_byte, m_out);
         chk(out_idx == m_oidx, {tag, " index"}, out_idx, m_oidx);
      end
   endtask

   task automatic t_reset();
      for (int i = 0; i < 16; i++) begin m_stage[i] = '0; m_live[i] = '0; end
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(out_byte == 8'h00, "R1 out_byte", out_byte, 0);
      chk(out_idx == 4'h0, "R1 out_idx", out_idx, 0);
      chk(ser_out == 1'b0, "R1 ser_out", ser_out, 0);
   endtask

   task automatic t_plain();
      for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 1'b1, 4'(i), 8'(8'hA5 ^ (i * 29)));
      step(1'b1, 1'b0, 1'b0, 4'd0, 8'd0);
      chk(out_byte == 8'hA5 && out_idx == 0, "R1 first byte", out_byte, 8'hA5);
      send(15, "R3 plain");
      send(1, "R2 wrap");
      chk(out_idx == 0, "R2 wrap index", out_idx, 0);
      send(15, "R3 plain second");
   endtask

   task automatic t_torn();
      logic [7:0] old7;
      old7 = m_live[7];
      send(5, "R6 pre");
      step(1'b0, 1'b0, 1'b1, 4'd7, 8'h3C);
      send(3, "R6 mid");
      chk(out_idx == 7 && out_byte == old7, "R6 not torn", out_byte, old7);
      send(8, "R6 rest");
      send(8, "R6 next");
      chk(out_idx == 7 && out_byte == 8'h3C, "R6 new frame", out_byte, 8'h3C);
      send(8, "R6 tail");
   endtask

   task automatic t_same_cycle();
      logic [7:0] old0;
      old0 = m_stage[0];
      step(1'b1, 1'b0, 1'b1, 4'd0, 8'h5A);
      chk(out_byte == old0, "R6 same-cycle old", out_byte, old0);
      send(15, "R6 same-cycle frame");
      send(1, "R6 same-cycle next");
      chk(out_byte == 8'h5A, "R6 same-cycle new", out_byte, 8'h5A);
      send(15, "R6 same-cycle tail");
   endtask

   task automatic t_align();
      align_en = 1'b1;
      send(16, "R4 marker");
   endtask

   task automatic t_invert();
      invert_en = 1'b1;
      send(1, "R5 both");
      chk(out_byte[7] == 1'b0, "R5 byte0 bit7", out_byte[7], 0);
      send(15, "R5 both");
      align_en = 1'b0;
      send(16, "R5 invert only");
      invert_en = 1'b0;
   endtask

   task automatic t_serial();
      send(1, "R7 load");
      chk(ser_out == m_sh[7], "R7 first bit", ser_out, m_sh[7]);
      for (int b = 0; b < 7; b++) begin
         step(1'b0, 1'b1, 1'b0, 4'd0, 8'd0);
         chk(ser_out == m_sh[7], "R7 shift", ser_out, m_sh[7]);
      end
      step(1'b1, 1'b1, 1'b0, 4'd0, 8'd0);
      chk(ser_out == m_out[7], "R8 load wins", ser_out, m_out[7]);
      chk(out_byte == m_out, "R8 byte", out_byte, m_out);
   endtask

   task automatic t_hold();
      logic [7:0] b;
      logic s;
      b = out_byte; s = ser_out;
      repeat (3) @(negedge clk);
      chk(out_byte == b && ser_out == s, "R9 idle hold", out_byte, b);
      step(1'b0, 1'b1, 1'b0, 4'd0, 8'd0);
      chk(out_byte == b, "R9 bit strobe keeps byte", out_byte, b);
      step(1'b0, 1'b0, 1'b1, 4'd3, 8'hFF);
      chk(out_byte == b && out_idx == m_oidx, "R9 write keeps byte", out_byte, b);
   endtask

   initial begin
      t_reset();
      t_plain();
      t_torn();
      t_same_cycle();
      t_align();
      t_invert();
      t_serial();
      t_hold();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule